// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the internal address for a short burst of up to four memory accesses. An address-strobe cycle captures the external address. Two strobes exist: one driven by a processor and one by a cache controller, and chip enable gates them differently. After the capture, each cycle with the advance input high steps the two low address bits. The step follows either a linear order or an interleaved order. The upper bits stay as captured. A cycle with no strobe and advance low suspends the burst, and the address holds.

The block also registers the chip-enable state on each accepted strobe. It gives the memory core a chip-select-valid flag and a copy of that flag delayed by one cycle. The memory array and the data path sit outside the block. The interface has no stream. Every pin is plain control or address, so there is no valid/ready handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low and in the cycle after its release, addr_o is all zeros and cs_valid_o and cs_valid_dly_o are 0.
- R2: A clock edge with proc_strb_i=1 and ce_i=1 captures addr_i. The next cycle shows it on addr_o.
- R3: A processor strobe with ce_i=0 is ignored. addr_o and cs_valid_o keep their values.
- R4: The controller strobe ctrl_strb_i captures addr_i only when ce_i, ce2_i and ce3_i are all 1. Otherwise it is ignored and addr_o and cs_valid_o hold.
- R5: When both strobes are high in one cycle, the processor strobe decides. An accepted processor capture sets cs_valid_o to the AND of the three enables, even if the controller strobe is also high.
- R6: With the order captured as 0 (linear), the two low bits after k advances equal (start + k) mod 4. Bits above bit 1 never change between captures.
- R7: With the order captured as 1 (interleaved), the two low bits after k advances equal start XOR (k mod 4).
- R8: mode_i is sampled only at a capture edge. Changing it during a burst does not change the order of that burst.
- R9: A cycle with no accepted strobe and adv_i=0 leaves addr_o unchanged.
- R10: After the fourth address, the next advance returns the two low bits to the start offset.
- R11: An accepted controller capture sets cs_valid_o to 1. An accepted processor capture sets it to ce_i&ce2_i&ce3_i. cs_valid_dly_o equals cs_valid_o from the previous cycle.
- R12: adv_i has no effect before the first accepted capture after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External address, captured on an accepted strobe |
| proc_strb_i | input | 1 | Processor address strobe, active high |
| ctrl_strb_i | input | 1 | Controller address strobe, active high |
| adv_i | input | 1 | Burst advance, active high |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce_i | input | 1 | Primary chip enable, active high |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_i | input | 1 | Third chip enable, active high |
| addr_o | output | ADDR_W | Internal burst address |
| cs_valid_o | output | 1 | Registered chip-select-valid flag |
| cs_valid_dly_o | output | 1 | cs_valid_o delayed by one cycle |

## Verification
Captures, advances and the chip-select-valid flag each take effect at one clock edge. Their results show on the outputs one cycle after the stimulus. The delayed flag shows one cycle after that. The bench changes inputs on the falling edge and checks outputs on the next falling edge, so each comparison lands half a period after the edge that produced the result. The bench checks the delayed flag one falling edge later still.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int OFF_W = 2;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  function automatic logic [OFF_W-1:0] burst_offset(
    input burst_order_e     order,
    input logic [OFF_W-1:0] start,
    input logic [OFF_W-1:0] step
  );
    if (order == ORDER_INTERLEAVED) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic proc_strb_i,
  input  logic ctrl_strb_i,
  input  logic ce_i,
  input  logic ce2_i,
  input  logic ce3_i,
  output logic load_o,
  output logic cs_valid_o,
  output logic cs_valid_dly_o
);
  logic all_ce;
  logic proc_take;
  logic ctrl_take;
  logic cs_q;
  logic cs_dly_q;

  assign all_ce    = ce_i & ce2_i & ce3_i;
  // processor strobe wins whenever it is present
  assign proc_take = proc_strb_i & ce_i;
  assign ctrl_take = ctrl_strb_i & ~proc_strb_i & all_ce;
  assign load_o    = proc_take | ctrl_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      cs_dly_q <= 1'b0;
    end else begin
      if (proc_take)      cs_q <= all_ce;
      else if (ctrl_take) cs_q <= 1'b1;
      cs_dly_q <= cs_q;
    end
  end

  assign cs_valid_o     = cs_q;
  assign cs_valid_dly_o = cs_dly_q;

  // R3 / R4: with primary enable low nothing may change the select flag
  p_ce_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(cs_valid_o));

  // R4: controller strobe with a missing enable leaves the flag alone
  p_ctrl_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strb_i && !proc_strb_i && !(ce_i && ce2_i && ce3_i)) |=> $stable(cs_valid_o));

  // R11: a rise of the flag is mirrored one cycle later
  p_dly_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_valid_o) |=> cs_valid_dly_o);
endmodule

// File: rtl/bas_offset_gen.sv
module bas_offset_gen
  import bas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             mode_i,
  input  logic [OFF_W-1:0] start_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] step_q;
  burst_order_e     order_q;
  logic             active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      step_q   <= '0;
      order_q  <= ORDER_LINEAR;
      active_q <= 1'b0;
    end else if (load_i) begin
      start_q  <= start_i;
      step_q   <= '0;
      order_q  <= burst_order_e'(mode_i);
      active_q <= 1'b1;
    end else if (adv_i && active_q) begin
      step_q <= step_q + OFF_W'(1);
    end
  end

  assign off_o = burst_offset(order_q, start_q, step_q);

  // R6: a linear advance moves the offset up by one, modulo the offset range
  p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && active_q && order_q == ORDER_LINEAR)
      |=> off_o == $past(off_o) + OFF_W'(1));

  // R7: an interleaved advance always changes the offset
  p_inter_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && active_q && order_q == ORDER_INTERLEAVED)
      |=> off_o != $past(off_o));

  // R12: before the first capture the offset stays at its reset value
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load_i) |=> off_o == '0);
endmodule

// File: rtl/bas_upper_reg.sv
module bas_upper_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // R6: upper bits only move on a capture
  p_upper_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_i,
  input  logic              ctrl_strb_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic              ce_i,
  input  logic              ce2_i,
  input  logic              ce3_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_valid_o,
  output logic              cs_valid_dly_o
);
  localparam int UP_W = ADDR_W - OFF_W;

  logic             load;
  logic [OFF_W-1:0] off;
  logic [UP_W-1:0]  upper;

  bas_load_ctrl u_load (
    .clk            (clk),
    .rst_n          (rst_n),
    .proc_strb_i    (proc_strb_i),
    .ctrl_strb_i    (ctrl_strb_i),
    .ce_i           (ce_i),
    .ce2_i          (ce2_i),
    .ce3_i          (ce3_i),
    .load_o         (load),
    .cs_valid_o     (cs_valid_o),
    .cs_valid_dly_o (cs_valid_dly_o)
  );

  bas_offset_gen u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .adv_i   (adv_i),
    .mode_i  (mode_i),
    .start_i (addr_i[OFF_W-1:0]),
    .off_o   (off)
  );

  bas_upper_reg #(.W(UP_W)) u_up (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .d_i    (addr_i[ADDR_W-1:OFF_W]),
    .q_o    (upper)
  );

  assign addr_o = {upper, off};

  // R2: an enabled processor strobe presents the captured address next cycle
  p_proc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_i && ce_i) |=> addr_o == $past(addr_i));

  // R9: suspend holds the whole address
  p_suspend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(proc_strb_i && ce_i) && !(ctrl_strb_i && ce_i && ce2_i && ce3_i) && !adv_i)
      |=> $stable(addr_o));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int ADDR_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic proc_strb_i = 0, ctrl_strb_i = 0, adv_i = 0, mode_i = 0;
  logic ce_i = 0, ce2_i = 0, ce3_i = 0;
  logic [ADDR_W-1:0] addr_o;
  logic cs_valid_o, cs_valid_dly_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .proc_strb_i(proc_strb_i), .ctrl_strb_i(ctrl_strb_i),
    .adv_i(adv_i), .mode_i(mode_i),
    .ce_i(ce_i), .ce2_i(ce2_i), .ce3_i(ce3_i),
    .addr_o(addr_o), .cs_valid_o(cs_valid_o), .cs_valid_dly_o(cs_valid_dly_o)
  );

  // entry: {order, start[1:0], upper nibble[3:0], advance mask[7:0] (bit0 first)}
  localparam logic [14:0] BURSTS [8] = '{
    {1'b0, 2'd0, 4'h3, 8'b1111_1111},
    {1'b0, 2'd1, 4'hA, 8'b1101_1011},
    {1'b0, 2'd2, 4'h5, 8'b1110_1101},
    {1'b0, 2'd3, 4'hC, 8'b1011_0111},
    {1'b1, 2'd0, 4'h9, 8'b1111_0111},
    {1'b1, 2'd1, 4'h6, 8'b1101_1111},
    {1'b1, 2'd2, 4'hF, 8'b0111_1011},
    {1'b1, 2'd3, 4'h1, 8'b1111_1101}
  };

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    proc_strb_i = 0; ctrl_strb_i = 0; adv_i = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] up_addr;
    logic [1:0] exp_off;
    int k;
    @(negedge clk);
    tick; tick;
    check("R1 addr", addr_o, '0);
    check("R1 cs", {17'd0, cs_valid_o}, 0);
    rst_n = 1;
    tick;
    check("R1 after release", addr_o, '0);
    check("R1 dly", {17'd0, cs_valid_dly_o}, 0);

    // R12: advance with no capture yet
    adv_i = 1; tick; tick; idle;
    check("R12 adv ignored", addr_o, '0);

    ce_i = 1; ce2_i = 1; ce3_i = 1;
    for (int b = 0; b < 8; b++) begin
      logic [14:0] e;
      e = BURSTS[b];
      up_addr = {{4{e[11:8]}}, e[13:12]};
      mode_i = e[14]; addr_i = up_addr; proc_strb_i = 1;
      tick; idle;
      check("R2 capture", addr_o, up_addr);
      k = 0;
      for (int i = 0; i < 8; i++) begin
        adv_i = e[i];
        if (e[i]) k++;
        tick;
        exp_off = e[14] ? (e[13:12] ^ 2'(k)) : (e[13:12] + 2'(k));
        if (!e[i])                check("R9 suspend", addr_o, {up_addr[ADDR_W-1:2], exp_off});
        else if (k % 4 == 0)      check("R10 wrap", addr_o, {up_addr[ADDR_W-1:2], exp_off});
        else if (e[14])           check("R7 interleaved", addr_o, {up_addr[ADDR_W-1:2], exp_off});
        else                      check("R6 linear", addr_o, {up_addr[ADDR_W-1:2], exp_off});
      end
      idle;
    end

    // R8: order fixed at capture
    mode_i = 1; addr_i = 18'h2_0001; proc_strb_i = 1; tick; idle;
    mode_i = 0; adv_i = 1; tick;
    check("R8 order latched k1", addr_o, 18'h2_0000);
    tick; idle;
    check("R8 order latched k2", addr_o, 18'h2_0003);

    // R3: processor strobe with primary enable low
    ce_i = 0; addr_i = 18'h1_1110; proc_strb_i = 1; tick; idle;
    check("R3 addr hold", addr_o, 18'h2_0003);
    check("R3 cs hold", {17'd0, cs_valid_o}, 1);

    // R4: controller strobe with third enable low
    ce_i = 1; ce3_i = 0; ctrl_strb_i = 1; tick; idle;
    check("R4 ignored", addr_o, 18'h2_0003);
    ce3_i = 1; addr_i = 18'h0_4442; ctrl_strb_i = 1; tick; idle;
    check("R4 loads", addr_o, 18'h0_4442);
    check("R11 ctrl cs", {17'd0, cs_valid_o}, 1);

    // R5: both strobes, second enable low: processor wins and deselects
    ce2_i = 0; addr_i = 18'h3_0F01; proc_strb_i = 1; ctrl_strb_i = 1; tick; idle;
    check("R5 proc addr", addr_o, 18'h3_0F01);
    check("R5 proc cs", {17'd0, cs_valid_o}, 0);
    check("R11 dly before", {17'd0, cs_valid_dly_o}, 1);
    tick;
    check("R11 dly after", {17'd0, cs_valid_dly_o}, 0);
    ce2_i = 1; ctrl_strb_i = 1; addr_i = 18'h0_0002; tick; idle;
    check("R11 ctrl sets cs", {17'd0, cs_valid_o}, 1);
    check("R11 dly lags", {17'd0, cs_valid_dly_o}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule